// File: doc/BRIEF.md
# Mailbox Doorbell Register File

This block is the adapter-side register window of a mailbox host interface. A host addresses sixteen byte registers over a simple strobe bus. It deposits a 32-bit outgoing-mail pointer and rings the adapter doorbell. The block then hands that pointer to the adapter core with a one-cycle request. The core clears the doorbell when it has taken the pointer. Going the other way, the core posts an incoming-mail pointer or a status event into the host doorbell. The host reads the pointer and acknowledges by writing ones to the doorbell bits it has serviced.

The two doorbells have opposite ownership. The host sets adapter-doorbell bits and the core clears them. The core sets host-doorbell bits and the host clears them. Each doorbell has its own mask register that gates an interrupt. The window also carries fixed identification and configuration bytes, taken from parameters. Two command bits request a soft reset and a bus reset; each stays set until the core reports that the reset is complete.

Top module: `mbx_doorbell_regs`

## Requirements
- R1: Synchronous reset clears both doorbells, both masks, both pointers and both reset requests, and drives host_irq, ogm_req and core_ogm_irq low.
- R2: A read is captured on the clock edge where h_rd is high, and h_rdata holds the result from that edge on. Offsets 0x04 and 0x05 read the ID byte (default 0x56) and the model byte (default 0x40). Offset 0x06 reads {dma_sel[1:0], irq_sel[1:0], 4'b0}, which is 0x50 by default. Offset 0x07 reads {5'b0, own_id}, which is 0x07 by default.
- R3: Offsets 0x08–0x0B hold the outgoing pointer in little-endian order (0x08 is the least significant byte), and the host can read it back. Host writes to these offsets are ignored while adapter doorbell bit 0 is set.
- R4: A host write to 0x01 with bit 0 set, made while adapter doorbell bit 0 is clear, sets that bit. On the same edge, ogm_req is high for exactly one cycle, with ogm_ptr valid. Ringing again while the bit is set gives no new pulse.
- R5: core_ogm_taken clears adapter doorbell bit 0. A host write of 0 to that bit leaves it set.
- R6: icm_post, when host doorbell bit 0 is clear, sets that bit and loads icm_ptr_in. The loaded pointer reads back little-endian at 0x0C–0x0F. A post made while the bit is set is ignored and leaves the stored pointer unchanged. icm_busy mirrors the bit.
- R7: A host write to 0x03 with bit 0 set clears host doorbell bit 0. A write with bit 0 clear leaves it unchanged.
- R8: stat_post sets host doorbell bit 7. A host write to 0x03 with bit 7 set clears it.
- R9: The host mask at 0x02 stores only bit 0 (mail enable) and bit 7 (status enable); its other bits read 0. host_irq equals (doorbell bit 0 AND mask bit 0) OR (doorbell bit 7 AND mask bit 7), and it changes on the same edge as those registers.
- R10: The adapter mask at 0x00 stores bit 0 and reads bit 6 as the soft-reset-allowed parameter (0x40 after reset by default). core_ogm_irq is high when adapter doorbell bit 0 and mask bit 0 are both set.
- R11: A host write to 0x01 with bit 6 set sets soft_rst_req (only when soft reset is allowed). A write with bit 5 set sets bus_rst_req. Both requests read back at 0x01 bits 6 and 5. rst_done clears both requests, unless a host write sets them on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | ADDR_W | Host register offset |
| h_wdata | input | 8 | Host write data |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | 8 | Registered host read data |
| host_irq | output | 1 | Masked host doorbell interrupt |
| ogm_ptr | output | 8*PTR_BYTES | Outgoing-mail pointer toward the core |
| ogm_req | output | 1 | One-cycle outgoing-mail request |
| ogm_taken | input | 1 | Core has consumed the outgoing pointer |
| core_ogm_irq | output | 1 | Masked adapter doorbell interrupt to the core |
| icm_ptr_in | input | 8*PTR_BYTES | Incoming-mail pointer from the core |
| icm_post | input | 1 | Core posts incoming mail |
| icm_busy | output | 1 | Incoming-mail slot still held by the host |
| stat_post | input | 1 | Core raises the status event bit |
| soft_rst_req | output | 1 | Soft reset request level |
| bus_rst_req | output | 1 | Bus reset request level |
| rst_done | input | 1 | Core has finished the requested reset |

## Verification
The outgoing path is tried in four ways: a ring from idle, a second ring while the request is pending, a pointer rewrite while the request is pending, and a write of zero to the doorbell. Together these separate a real edge-detected request from a level copy of the bit, and a guarded pointer from an unguarded one. The incoming path is tried with a post into a free slot and a post into an occupied slot. It is also tried with acknowledges whose value bits are zero and whose value bits are one. The host interrupt is exercised with each mask bit on and off for each source, so that a swapped or missing gate shows up on host_irq. Bytes are written with distinct values in each lane, which makes any byte-order error visible. The reset requests are set one at a time, so that each readback bit can be told apart before the completion clears both.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // register offsets; pointer windows start at the listed base
  localparam int OFS_AMASK = 0;
  localparam int OFS_ADB   = 1;
  localparam int OFS_HMASK = 2;
  localparam int OFS_HDB   = 3;
  localparam int OFS_PID0  = 4;
  localparam int OFS_PID1  = 5;
  localparam int OFS_CFG1  = 6;
  localparam int OFS_CFG2  = 7;
  localparam int OFS_OGM   = 8;
  localparam int OFS_ICM   = 12;

  // doorbell bit positions
  localparam int BIT_MAIL    = 0;
  localparam int BIT_BUSRST  = 5;
  localparam int BIT_SOFTRST = 6;
  localparam int BIT_STAT    = 7;

  typedef struct packed {
    logic softrst;
    logic busrst;
    logic mail;
  } adb_state_t;

  typedef struct packed {
    logic stat;
    logic mail;
  } hdb_state_t;
endpackage

// File: rtl/mbx_ptr_reg.sv
module mbx_ptr_reg #(
  parameter int ADDR_W = 4,
  parameter int BYTES  = 4,
  parameter int BASE   = 8,
  localparam int W     = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              load,
  input  logic [W-1:0]      load_val,
  output logic [W-1:0]      q
);
  logic [7:0] lane_q [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE + g);
    always_ff @(posedge clk) begin
      if (rst)
        lane_q[g] <= '0;
      else if (load)
        lane_q[g] <= load_val[8*g +: 8];
      else if (wr_en && wr_addr == LANE_ADDR)
        lane_q[g] <= wr_data;
    end
    assign q[8*g +: 8] = lane_q[g];
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter bit SOFT_RST_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [7:0]        h_wdata,
  input  logic              ogm_taken,
  input  logic              icm_post,
  input  logic              stat_post,
  input  logic              rst_done,
  output logic [7:0]        amask_byte,
  output logic [7:0]        adb_byte,
  output logic [7:0]        hmask_byte,
  output logic [7:0]        hdb_byte,
  output logic              host_irq,
  output logic              core_ogm_irq,
  output logic              ogm_req,
  output logic              icm_accept
);
  localparam logic [ADDR_W-1:0] A_AMASK = ADDR_W'(OFS_AMASK);
  localparam logic [ADDR_W-1:0] A_ADB   = ADDR_W'(OFS_ADB);
  localparam logic [ADDR_W-1:0] A_HMASK = ADDR_W'(OFS_HMASK);
  localparam logic [ADDR_W-1:0] A_HDB   = ADDR_W'(OFS_HDB);

  adb_state_t adb_q, adb_d;
  hdb_state_t hdb_q, hdb_d, hmask_q, hmask_d;
  logic       amask_q, amask_d;
  logic       host_irq_q, core_irq_q, ogm_req_q;
  logic       wr_amask, wr_adb, wr_hmask, wr_hdb, ring;

  assign wr_amask = h_wr && (h_addr == A_AMASK);
  assign wr_adb   = h_wr && (h_addr == A_ADB);
  assign wr_hmask = h_wr && (h_addr == A_HMASK);
  assign wr_hdb   = h_wr && (h_addr == A_HDB);

  assign ring       = wr_adb && h_wdata[BIT_MAIL] && !adb_q.mail;
  assign icm_accept = icm_post && !hdb_q.mail;

  always_comb begin
    adb_d = adb_q;
    if (ring)
      adb_d.mail = 1'b1;
    else if (ogm_taken)
      adb_d.mail = 1'b0;
    if (rst_done) begin
      adb_d.softrst = 1'b0;
      adb_d.busrst  = 1'b0;
    end
    if (wr_adb && h_wdata[BIT_SOFTRST] && SOFT_RST_OK)
      adb_d.softrst = 1'b1;
    if (wr_adb && h_wdata[BIT_BUSRST])
      adb_d.busrst = 1'b1;

    hdb_d = hdb_q;
    if (wr_hdb && h_wdata[BIT_MAIL])
      hdb_d.mail = 1'b0;
    if (icm_accept)
      hdb_d.mail = 1'b1;
    if (wr_hdb && h_wdata[BIT_STAT])
      hdb_d.stat = 1'b0;
    if (stat_post)
      hdb_d.stat = 1'b1;

    hmask_d = hmask_q;
    if (wr_hmask) begin
      hmask_d.mail = h_wdata[BIT_MAIL];
      hmask_d.stat = h_wdata[BIT_STAT];
    end

    amask_d = wr_amask ? h_wdata[BIT_MAIL] : amask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adb_q      <= '0;
      hdb_q      <= '0;
      hmask_q    <= '0;
      amask_q    <= 1'b0;
      host_irq_q <= 1'b0;
      core_irq_q <= 1'b0;
      ogm_req_q  <= 1'b0;
    end else begin
      adb_q      <= adb_d;
      hdb_q      <= hdb_d;
      hmask_q    <= hmask_d;
      amask_q    <= amask_d;
      host_irq_q <= (hdb_d.mail & hmask_d.mail) | (hdb_d.stat & hmask_d.stat);
      core_irq_q <= adb_d.mail & amask_d;
      ogm_req_q  <= ring;
    end
  end

  assign amask_byte   = {1'b0, SOFT_RST_OK, 5'b0, amask_q};
  assign adb_byte     = {1'b0, adb_q.softrst, adb_q.busrst, 4'b0, adb_q.mail};
  assign hmask_byte   = {hmask_q.stat, 6'b0, hmask_q.mail};
  assign hdb_byte     = {hdb_q.stat, 6'b0, hdb_q.mail};
  assign host_irq     = host_irq_q;
  assign core_ogm_irq = core_irq_q;
  assign ogm_req      = ogm_req_q;
endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
  import mbx_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter int         PTR_BYTES = 4,
  parameter logic [7:0] PID_LO    = 8'h56,
  parameter logic [7:0] MODEL     = 8'h40,
  parameter logic [7:0] CFG1      = 8'h50,
  parameter logic [7:0] CFG2      = 8'h07,
  localparam int        PTR_W     = 8 * PTR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_rd,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [7:0]        amask_byte,
  input  logic [7:0]        adb_byte,
  input  logic [7:0]        hmask_byte,
  input  logic [7:0]        hdb_byte,
  input  logic [PTR_W-1:0]  ogm_ptr,
  input  logic [PTR_W-1:0]  icm_ptr,
  output logic [7:0]        h_rdata
);
  logic [7:0] sel;

  always_comb begin
    sel = 8'h00;
    if (h_addr == ADDR_W'(OFS_AMASK)) sel = amask_byte;
    if (h_addr == ADDR_W'(OFS_ADB))   sel = adb_byte;
    if (h_addr == ADDR_W'(OFS_HMASK)) sel = hmask_byte;
    if (h_addr == ADDR_W'(OFS_HDB))   sel = hdb_byte;
    if (h_addr == ADDR_W'(OFS_PID0))  sel = PID_LO;
    if (h_addr == ADDR_W'(OFS_PID1))  sel = MODEL;
    if (h_addr == ADDR_W'(OFS_CFG1))  sel = CFG1;
    if (h_addr == ADDR_W'(OFS_CFG2))  sel = CFG2;
    for (int i = 0; i < PTR_BYTES; i++) begin
      if (h_addr == ADDR_W'(OFS_OGM + i)) sel = ogm_ptr[8*i +: 8];
      if (h_addr == ADDR_W'(OFS_ICM + i)) sel = icm_ptr[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      h_rdata <= 8'h00;
    else if (h_rd)
      h_rdata <= sel;
  end
endmodule

// File: rtl/mbx_doorbell_regs.sv
module mbx_doorbell_regs #(
  parameter int         ADDR_W      = 4,
  parameter int         PTR_BYTES   = 4,
  parameter logic [7:0] PID_LO      = 8'h56,
  parameter logic [7:0] MODEL       = 8'h40,
  parameter logic [1:0] IRQ_SEL     = 2'd1,
  parameter logic [1:0] DMA_SEL     = 2'd1,
  parameter logic [2:0] OWN_ID      = 3'd7,
  parameter bit         SOFT_RST_OK = 1'b1,
  localparam int        PTR_W       = 8 * PTR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [7:0]        h_wdata,
  input  logic              h_wr,
  input  logic              h_rd,
  output logic [7:0]        h_rdata,
  output logic              host_irq,
  output logic [PTR_W-1:0]  ogm_ptr,
  output logic              ogm_req,
  input  logic              ogm_taken,
  output logic              core_ogm_irq,
  input  logic [PTR_W-1:0]  icm_ptr_in,
  input  logic              icm_post,
  output logic              icm_busy,
  input  logic              stat_post,
  output logic              soft_rst_req,
  output logic              bus_rst_req,
  input  logic              rst_done
);
  localparam logic [7:0] CFG1 = {DMA_SEL, IRQ_SEL, 4'b0000};
  localparam logic [7:0] CFG2 = {5'b00000, OWN_ID};

  logic [7:0]       amask_byte, adb_byte, hmask_byte, hdb_byte;
  logic             icm_accept;
  logic [PTR_W-1:0] icm_ptr;

  mbx_doorbell #(.ADDR_W(ADDR_W), .SOFT_RST_OK(SOFT_RST_OK)) u_db (
    .clk(clk), .rst(rst), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .ogm_taken(ogm_taken), .icm_post(icm_post), .stat_post(stat_post),
    .rst_done(rst_done), .amask_byte(amask_byte), .adb_byte(adb_byte),
    .hmask_byte(hmask_byte), .hdb_byte(hdb_byte), .host_irq(host_irq),
    .core_ogm_irq(core_ogm_irq), .ogm_req(ogm_req), .icm_accept(icm_accept)
  );

  // outgoing pointer: host lanes, frozen while the doorbell is up
  mbx_ptr_reg #(.ADDR_W(ADDR_W), .BYTES(PTR_BYTES), .BASE(mbx_pkg::OFS_OGM)) u_ogm (
    .clk(clk), .rst(rst), .wr_en(h_wr && !adb_byte[mbx_pkg::BIT_MAIL]),
    .wr_addr(h_addr), .wr_data(h_wdata), .load(1'b0), .load_val('0), .q(ogm_ptr)
  );

  // incoming pointer: loaded whole by the core only
  mbx_ptr_reg #(.ADDR_W(ADDR_W), .BYTES(PTR_BYTES), .BASE(mbx_pkg::OFS_ICM)) u_icm (
    .clk(clk), .rst(rst), .wr_en(1'b0), .wr_addr(h_addr), .wr_data(h_wdata),
    .load(icm_accept), .load_val(icm_ptr_in), .q(icm_ptr)
  );

  mbx_rd_mux #(
    .ADDR_W(ADDR_W), .PTR_BYTES(PTR_BYTES), .PID_LO(PID_LO), .MODEL(MODEL),
    .CFG1(CFG1), .CFG2(CFG2)
  ) u_rd (
    .clk(clk), .rst(rst), .h_rd(h_rd), .h_addr(h_addr),
    .amask_byte(amask_byte), .adb_byte(adb_byte), .hmask_byte(hmask_byte),
    .hdb_byte(hdb_byte), .ogm_ptr(ogm_ptr), .icm_ptr(icm_ptr), .h_rdata(h_rdata)
  );

  assign icm_busy     = hdb_byte[mbx_pkg::BIT_MAIL];
  assign soft_rst_req = adb_byte[mbx_pkg::BIT_SOFTRST];
  assign bus_rst_req  = adb_byte[mbx_pkg::BIT_BUSRST];
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
  parameter int ADDR_W = 4,
  parameter int PTR_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              h_wr,
  input logic [ADDR_W-1:0] h_addr,
  input logic              host_irq,
  input logic              ogm_req,
  input logic              ogm_taken,
  input logic [PTR_W-1:0]  ogm_ptr,
  input logic [PTR_W-1:0]  icm_ptr,
  input logic [7:0]        adb_byte,
  input logic [7:0]        hdb_byte,
  input logic              soft_rst_req,
  input logic              bus_rst_req,
  input logic              rst_done
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!host_irq && !ogm_req && adb_byte == 8'h00 && hdb_byte == 8'h00));

  // R4
  ogm_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ogm_req |=> !ogm_req);

  // R4
  ogm_req_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ogm_req |-> (adb_byte[0] && !$past(adb_byte[0])));

  // R3
  ogm_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adb_byte[0] && $past(adb_byte[0])) |-> $stable(ogm_ptr));

  // R5
  ogm_taken_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ogm_taken && adb_byte[0]) |=> !adb_byte[0]);

  // R6
  icm_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hdb_byte[0] && $past(hdb_byte[0])) |-> $stable(icm_ptr));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> (hdb_byte[0] || hdb_byte[7]));

  // R11
  rst_req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_done && !(h_wr && h_addr == ADDR_W'(1))) |=> (!soft_rst_req && !bus_rst_req));
endmodule

bind mbx_doorbell_regs mbx_doorbell_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .h_wr(h_wr), .h_addr(h_addr), .host_irq(host_irq),
  .ogm_req(ogm_req), .ogm_taken(ogm_taken), .ogm_ptr(ogm_ptr), .icm_ptr(icm_ptr),
  .adb_byte(adb_byte), .hdb_byte(hdb_byte), .soft_rst_req(soft_rst_req),
  .bus_rst_req(bus_rst_req), .rst_done(rst_done)
);

// File: tb/tb_mbx_doorbell_regs.sv
module tb_mbx_doorbell_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  h_addr = '0;
  logic [7:0]  h_wdata = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0]  h_rdata;
  logic        host_irq, ogm_req, core_ogm_irq, icm_busy, soft_rst_req, bus_rst_req;
  logic [31:0] ogm_ptr;
  logic        ogm_taken = 1'b0, icm_post = 1'b0, stat_post = 1'b0, rst_done = 1'b0;
  logic [31:0] icm_ptr_in = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic rd_pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  mbx_doorbell_regs dut (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_wdata(h_wdata), .h_wr(h_wr),
    .h_rd(h_rd), .h_rdata(h_rdata), .host_irq(host_irq), .ogm_ptr(ogm_ptr),
    .ogm_req(ogm_req), .ogm_taken(ogm_taken), .core_ogm_irq(core_ogm_irq),
    .icm_ptr_in(icm_ptr_in), .icm_post(icm_post), .icm_busy(icm_busy),
    .stat_post(stat_post), .soft_rst_req(soft_rst_req), .bus_rst_req(bus_rst_req),
    .rst_done(rst_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard queue
  always @(posedge clk) rd_pend <= h_rd;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {24'h0, h_rdata}, {24'h0, e});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk); h_rd = 1'b1; h_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); h_rd = 1'b0;
  endtask

  task automatic pulse_taken();
    @(negedge clk); ogm_taken = 1'b1; @(negedge clk); ogm_taken = 1'b0;
  endtask

  task automatic pulse_icm(input logic [31:0] p);
    @(negedge clk); icm_post = 1'b1; icm_ptr_in = p;
    @(negedge clk); icm_post = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_post = 1'b1; @(negedge clk); stat_post = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); rst_done = 1'b1; @(negedge clk); rst_done = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 host_irq", {31'b0, host_irq}, 0);
    chk("R1 ogm_req", {31'b0, ogm_req}, 0);
    chk("R1 soft/bus", {30'b0, soft_rst_req, bus_rst_req}, 0);
    rd(4'h1, 8'h00, "R1 adb");
    rd(4'h3, 8'h00, "R1 hdb");
    rd(4'h8, 8'h00, "R1 ogm byte0");
    rd(4'h0, 8'h40, "R10 amask reset");
    // R2 identification
    rd(4'h4, 8'h56, "R2 id");
    rd(4'h5, 8'h40, "R2 model");
    rd(4'h6, 8'h50, "R2 cfg1");
    rd(4'h7, 8'h07, "R2 cfg2");
    // R3 pointer lanes
    wr(4'h8, 8'h78); wr(4'h9, 8'h56); wr(4'hA, 8'h34); wr(4'hB, 8'h12);
    rd(4'h8, 8'h78, "R3 lane0");
    rd(4'hB, 8'h12, "R3 lane3");
    // R4 ring
    wr(4'h1, 8'h01);
    chk("R4 req high", {31'b0, ogm_req}, 1);
    chk("R4 ptr", ogm_ptr, 32'h12345678);
    chk("R10 irq masked", {31'b0, core_ogm_irq}, 0);
    @(negedge clk);
    chk("R4 req one cycle", {31'b0, ogm_req}, 0);
    rd(4'h1, 8'h01, "R4 adb set");
    // R3 guarded write, R4 no re-pulse
    wr(4'h8, 8'hAA);
    rd(4'h8, 8'h78, "R3 write ignored while pending");
    wr(4'h1, 8'h01);
    chk("R4 no second pulse", {31'b0, ogm_req}, 0);
    // R5
    wr(4'h1, 8'h00);
    rd(4'h1, 8'h01, "R5 host cannot clear");
    pulse_taken();
    rd(4'h1, 8'h00, "R5 taken clears");
    // R10 adapter mask
    wr(4'h0, 8'hFF);
    rd(4'h0, 8'h41, "R10 amask stored");
    wr(4'h1, 8'h01);
    chk("R10 core irq", {31'b0, core_ogm_irq}, 1);
    pulse_taken();
    chk("R10 core irq drop", {31'b0, core_ogm_irq}, 0);
    // R9 mask store
    wr(4'h2, 8'hFF);
    rd(4'h2, 8'h81, "R9 hmask bits");
    // R6 incoming
    pulse_icm(32'hCAFEF00D);
    chk("R9 irq mail", {31'b0, host_irq}, 1);
    chk("R6 busy", {31'b0, icm_busy}, 1);
    rd(4'h3, 8'h01, "R6 hdb");
    rd(4'hC, 8'h0D, "R6 lane0");
    rd(4'hF, 8'hCA, "R6 lane3");
    pulse_icm(32'h11111111);
    rd(4'hC, 8'h0D, "R6 post ignored");
    // R7
    wr(4'h3, 8'h00);
    rd(4'h3, 8'h01, "R7 zero keeps");
    wr(4'h3, 8'h01);
    chk("R7 irq cleared", {31'b0, host_irq}, 0);
    chk("R7 busy cleared", {31'b0, icm_busy}, 0);
    // R8 status
    pulse_stat();
    chk("R8 irq stat", {31'b0, host_irq}, 1);
    rd(4'h3, 8'h80, "R8 hdb stat");
    wr(4'h2, 8'h01);
    chk("R9 stat masked", {31'b0, host_irq}, 0);
    wr(4'h3, 8'h80);
    rd(4'h3, 8'h00, "R8 stat cleared");
    wr(4'h2, 8'h00);
    pulse_icm(32'h0);
    chk("R9 mail masked", {31'b0, host_irq}, 0);
    wr(4'h3, 8'h01);
    // R11 reset requests
    wr(4'h1, 8'h40);
    chk("R11 soft", {31'b0, soft_rst_req}, 1);
    rd(4'h1, 8'h40, "R11 soft readback");
    wr(4'h1, 8'h20);
    chk("R11 bus", {31'b0, bus_rst_req}, 1);
    rd(4'h1, 8'h60, "R11 both readback");
    pulse_done();
    chk("R11 cleared", {30'b0, soft_rst_req, bus_rst_req}, 0);
    rd(4'h1, 8'h00, "R11 readback clear");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule